// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block takes each bus request and finds which of eight programmable memory banks should serve it. Each bank holds two configuration words. The base word carries a base address, an address-type value, a port size, a write-protect bit, a parity-enable bit and a valid bit. The option word carries an address mask and an address-type mask. A bank hits when it is valid and, once the mask is applied, both the request address and the request address type equal the bank's values. When several banks hit, the one with the lowest index wins. A request from an external master is always matched as if its address type were binary 100.

The winning bank's attributes drive a registered one-hot select. The block also checks that the access size and alignment fit the bank's port width. An access that does not fit raises an alignment error. A write to a protected bank raises a write-protect error and sets a sticky status bit, which software clears by writing 1. In both error cases no bank is selected. The block makes no timing strobes for the memory devices.

Configuration and status share one write port. `cfg_addr[IDX_W+1:IDX_W]` picks the target: 0 means the base word, 1 the option word, 2 the status word. The low `IDX_W` bits pick the bank.

Base word layout: [31:15] base address bits 31..15, [11:9] address type, [7:6] port size (01 = 8-bit, 10 = 16-bit, 11 = 32-bit, 00 = no access allowed), [2] parity enable, [1] write protect, [0] valid. Option word layout: [31:15] address mask, [11:9] address-type mask. A mask bit of 1 means the bit is compared. Status word: bit 0 is the write-protect error. Access size `req_size`: 0 = byte, 1 = halfword, 2 = word, 3 = illegal.

Top module: `csbank_decoder`

## Requirements
- R1: After reset every bank is invalid, so no request selects a bank. A bank takes part in matching only after its base word has been written with bit 0 set, and configuration writes apply to requests from the next cycle on.
- R2: A bank hits when `((req_addr[31:15] ^ base) & addr_mask) == 0` and `((type ^ base_type) & type_mask) == 0`. A bank whose type does not match under its mask does not hit.
- R3: When several banks hit, only the lowest-indexed one is selected.
- R4: When `req_ext` is 1, the type used for matching is 3'b100, whatever `req_at` holds.
- R5: One cycle after a valid request, `bank_sel` has exactly one bit set (the winner), and `sel_ps` and `sel_par` carry that bank's port size and parity enable. In every other case `bank_sel`, `sel_ps` and `sel_par` are zero.
- R6: A legal write to a bank with write protect set selects no bank. It pulses `wp_err` for one cycle and sets `stat_wper`. Reads from that bank, and writes to unprotected banks, are served normally.
- R7: `stat_wper` stays set until a status write with data bit 0 = 1. A status write with bit 0 = 0 has no effect. A new violation in the same cycle as a clear leaves it set.
- R8: A port of size 01 (8-bit) accepts byte accesses at any address and nothing else.
- R9: A port of size 10 (16-bit) accepts bytes at any address and halfwords with `req_addr[0]` = 0. Words are refused.
- R10: A port of size 11 (32-bit) accepts bytes, halfwords with `req_addr[0]` = 0, and words with `req_addr[1:0]` = 0.
- R11: A hit whose access is refused by R8 to R10, or whose size code is 3, pulses `align_err` with no select. On a protected bank it does not flag a write-protect error.
- R12: A request that hits no bank leaves every output low and `stat_wper` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration or status write strobe |
| cfg_addr | input | IDX_W+2 | Write target: kind in the top two bits, bank in the low bits |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Bus request strobe |
| req_addr | input | ADDR_W | Request address |
| req_at | input | AT_W | Request address type |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_ext | input | 1 | Request comes from an external master |
| bank_sel | output | NUM_BANKS | Registered one-hot bank select |
| sel_ps | output | 2 | Port size of the selected bank |
| sel_par | output | 1 | Parity enable of the selected bank |
| align_err | output | 1 | Size or alignment refused by the port |
| wp_err | output | 1 | Write-protect violation pulse |
| stat_wper | output | 1 | Sticky write-protect error status |

## Verification
Two events can land in the same cycle: software clearing the sticky write-protect bit, and a new protected write setting it. The bench provokes this by driving a status write with bit 0 = 1 in the same cycle as a write request to the protected bank. It then expects `stat_wper` to still read 1 afterwards, and to fall only after a later clear that has no violation next to it. The alignment check and the protect check can also fire on the same request. A misaligned write to the protected bank has to report only the alignment error and leave the status bit alone.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  // Configuration word field positions
  localparam int BF_AT_LO  = 9;
  localparam int BF_PS_LO  = 6;
  localparam int BF_PAR    = 2;
  localparam int BF_WP     = 1;
  localparam int BF_VALID  = 0;
  localparam int OF_ATM_LO = 9;
  localparam int CFG_DW    = 32;

  typedef enum logic [1:0] {
    KIND_BASE   = 2'd0,
    KIND_OPTION = 2'd1,
    KIND_STATUS = 2'd2
  } cfg_kind_e;

  typedef enum logic [1:0] {
    PS_NONE = 2'b00,
    PS_8    = 2'b01,
    PS_16   = 2'b10,
    PS_32   = 2'b11
  } port_size_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/csdec_bank_cmp.sv
module csdec_bank_cmp #(
  parameter int CMP_W = 17,
  parameter int AT_W  = 3
) (
  input  logic             valid,
  input  logic [CMP_W-1:0] base_addr,
  input  logic [CMP_W-1:0] mask_addr,
  input  logic [AT_W-1:0]  base_at,
  input  logic [AT_W-1:0]  mask_at,
  input  logic [CMP_W-1:0] req_addr_hi,
  input  logic [AT_W-1:0]  req_at,
  output logic             hit
);
  logic addr_eq;
  logic at_eq;

  always_comb begin
    addr_eq = ((req_addr_hi ^ base_addr) & mask_addr) == '0;
    at_eq   = ((req_at ^ base_at) & mask_at) == '0;
    hit     = valid & addr_eq & at_eq;
  end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = req & (~req + N'(1));
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/csdec_size_chk.sv
module csdec_size_chk
  import csdec_pkg::*;
(
  input  logic [1:0] ps,
  input  logic [1:0] size,
  input  logic [1:0] lsb,
  output logic       legal
);
  always_comb begin
    legal = 1'b0;
    unique case (port_size_e'(ps))
      PS_8:    legal = (size == SZ_BYTE);
      PS_16:   legal = (size == SZ_BYTE) || (size == SZ_HALF && !lsb[0]);
      PS_32:   legal = (size == SZ_BYTE) || (size == SZ_HALF && !lsb[0]) ||
                       (size == SZ_WORD && lsb == 2'b00);
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/csbank_decoder.sv
module csbank_decoder
  import csdec_pkg::*;
#(
  parameter int            NUM_BANKS = 8,
  parameter int            ADDR_W    = 32,
  parameter int            CMP_LSB   = 15,
  parameter int            AT_W      = 3,
  parameter logic [AT_W-1:0] EXT_AT  = 3'b100,
  localparam int           IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int           CFG_AW    = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [AT_W-1:0]      req_at,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic                 req_ext,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [1:0]           sel_ps,
  output logic                 sel_par,
  output logic                 align_err,
  output logic                 wp_err,
  output logic                 stat_wper
);
  localparam int CMP_W = ADDR_W - CMP_LSB;

  // Configuration storage
  logic [CFG_DW-1:0] base_q [NUM_BANKS];
  logic [CFG_DW-1:0] opt_q  [NUM_BANKS];

  cfg_kind_e        wr_kind;
  logic [IDX_W-1:0] wr_idx;
  logic             sts_clr;

  always_comb begin
    wr_kind = cfg_kind_e'(cfg_addr[CFG_AW-1 -: 2]);
    wr_idx  = cfg_addr[IDX_W-1:0];
    sts_clr = cfg_wr && (wr_kind == KIND_STATUS) && cfg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
    end else if (cfg_wr && (32'(wr_idx) < NUM_BANKS)) begin
      if (wr_kind == KIND_BASE)   base_q[wr_idx] <= cfg_wdata;
      if (wr_kind == KIND_OPTION) opt_q[wr_idx]  <= cfg_wdata;
    end
  end

  // Per-bank match
  logic [AT_W-1:0]      eff_at;
  logic [NUM_BANKS-1:0] hit_vec;
  logic [1:0]           ps_a  [NUM_BANKS];
  logic                 par_a [NUM_BANKS];
  logic                 wp_a  [NUM_BANKS];

  assign eff_at = req_ext ? EXT_AT : req_at;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign ps_a[g]  = base_q[g][BF_PS_LO +: 2];
    assign par_a[g] = base_q[g][BF_PAR];
    assign wp_a[g]  = base_q[g][BF_WP];

    csdec_bank_cmp #(
      .CMP_W(CMP_W),
      .AT_W (AT_W)
    ) i_cmp (
      .valid      (base_q[g][BF_VALID]),
      .base_addr  (base_q[g][CFG_DW-1 -: CMP_W]),
      .mask_addr  (opt_q[g][CFG_DW-1 -: CMP_W]),
      .base_at    (base_q[g][BF_AT_LO +: AT_W]),
      .mask_at    (opt_q[g][OF_ATM_LO +: AT_W]),
      .req_addr_hi(req_addr[ADDR_W-1:CMP_LSB]),
      .req_at     (eff_at),
      .hit        (hit_vec[g])
    );
  end

  // Priority and winner attributes
  logic [NUM_BANKS-1:0] win_oh;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_hit;
  logic [1:0]           win_ps;
  logic                 win_par;
  logic                 win_wp;
  logic                 size_ok;

  csdec_prio #(.N(NUM_BANKS)) i_prio (
    .req  (hit_vec),
    .grant(win_oh),
    .idx  (win_idx),
    .any  (any_hit)
  );

  always_comb begin
    win_ps  = ps_a[win_idx];
    win_par = par_a[win_idx];
    win_wp  = wp_a[win_idx];
  end

  csdec_size_chk i_size (
    .ps   (win_ps),
    .size (req_size),
    .lsb  (req_addr[1:0]),
    .legal(size_ok)
  );

  // Outcome
  logic do_hit;
  logic do_align;
  logic do_wp;

  always_comb begin
    do_hit   = req_valid && any_hit;
    do_align = do_hit && !size_ok;
    do_wp    = do_hit && size_ok && req_write && win_wp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel  <= '0;
      sel_ps    <= '0;
      sel_par   <= 1'b0;
      align_err <= 1'b0;
      wp_err    <= 1'b0;
      stat_wper <= 1'b0;
    end else begin
      align_err <= do_align;
      wp_err    <= do_wp;
      if (do_hit && !do_align && !do_wp) begin
        bank_sel <= win_oh;
        sel_ps   <= win_ps;
        sel_par  <= win_par;
      end else begin
        bank_sel <= '0;
        sel_ps   <= '0;
        sel_par  <= 1'b0;
      end
      // a new violation takes precedence over a clear in the same cycle
      if (do_wp)        stat_wper <= 1'b1;
      else if (sts_clr) stat_wper <= 1'b0;
    end
  end
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
  parameter int NUM_BANKS = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_wr,
  input logic [IDX_W+1:0]     cfg_addr,
  input logic [31:0]          cfg_wdata,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic [1:0]           sel_ps,
  input logic                 sel_par,
  input logic                 align_err,
  input logic                 wp_err,
  input logic                 stat_wper
);
  logic clr_w;
  assign clr_w = cfg_wr && (cfg_addr[IDX_W+1:IDX_W] == 2'd2) && cfg_wdata[0];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel)); // R5

  AST_ATTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bank_sel == '0) |-> (sel_ps == 2'b00 && !sel_par)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (bank_sel == '0 && !align_err && !wp_err)); // R5

  AST_ALIGN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (bank_sel == '0 && !wp_err)); // R11

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    wp_err |-> (bank_sel == '0 && stat_wper)); // R6

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!stat_wper && !(req_valid && req_write)) |=> !stat_wper); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stat_wper && !clr_w) |=> stat_wper); // R7
endmodule

bind csbank_decoder csdec_checker #(
  .NUM_BANKS(NUM_BANKS),
  .IDX_W    (IDX_W)
) i_csdec_checker (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .req_valid(req_valid),
  .req_write(req_write),
  .bank_sel (bank_sel),
  .sel_ps   (sel_ps),
  .sel_par  (sel_par),
  .align_err(align_err),
  .wp_err   (wp_err),
  .stat_wper(stat_wper)
);

// File: tb/test_csbank_decoder.sv
`timescale 1ns/1ps
module test_csbank_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_at = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_ext = 1'b0;
  logic [7:0]  bank_sel;
  logic [1:0]  sel_ps;
  logic        sel_par;
  logic        align_err;
  logic        wp_err;
  logic        stat_wper;

  always #4 clk = ~clk; // 125 MHz

  csbank_decoder i_csbank_decoder (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_at(req_at), .req_write(req_write),
    .req_size(req_size), .req_ext(req_ext), .bank_sel(bank_sel), .sel_ps(sel_ps),
    .sel_par(sel_par), .align_err(align_err), .wp_err(wp_err), .stat_wper(stat_wper)
  );

  typedef struct {
    int          due;
    logic [7:0]  sel;
    logic [1:0]  ps;
    logic        par;
    logic        al;
    logic        wp;
    logic        sts;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic sts_m = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_base(logic [16:0] ba, logic [2:0] at, logic [1:0] ps,
                                          logic par, logic wp, logic v);
    return {ba, 3'b0, at, 1'b0, ps, 3'b0, par, wp, v};
  endfunction

  function automatic logic [31:0] mk_opt(logic [16:0] am, logic [2:0] atm);
    return {am, 3'b0, atm, 9'b0};
  endfunction

  task automatic wr_cfg(input logic [1:0] kind, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = {kind, 3'(idx)}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // One request cycle (optionally with a status write), then push the expected result
  task automatic req(input logic v, input logic [31:0] a, input logic [2:0] at, input logic ext,
                     input logic wr, input logic [1:0] sz, input logic clr_en, input logic clr_v,
                     input logic [7:0] e_sel, input logic [1:0] e_ps, input logic e_par,
                     input logic e_al, input logic e_wp, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_addr = a; req_at = at; req_ext = ext; req_write = wr; req_size = sz;
    cfg_wr = clr_en; cfg_addr = {2'd2, 3'd0}; cfg_wdata = {31'b0, clr_v};
    if (e_wp) sts_m = 1'b1;
    else if (clr_en && clr_v) sts_m = 1'b0;
    e.due = cyc + 1; e.sel = e_sel; e.ps = e_ps; e.par = e_par;
    e.al = e_al; e.wp = e_wp; e.sts = sts_m; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; cfg_wr = 1'b0;
  endtask

  // Monitor: compares outputs against the scoreboard away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (bank_sel !== e.sel || sel_ps !== e.ps || sel_par !== e.par ||
            align_err !== e.al || wp_err !== e.wp || stat_wper !== e.sts) begin
          n_fail++;
          $display("FAIL %s: sel=%h ps=%b par=%b al=%b wp=%b sts=%b expected sel=%h ps=%b par=%b al=%b wp=%b sts=%b",
                   e.tag, bank_sel, sel_ps, sel_par, align_err, wp_err, stat_wper,
                   e.sel, e.ps, e.par, e.al, e.wp, e.sts);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state, then no bank configured
    req(0, 32'h0, 3'd0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R1 reset idle");
    req(1, 32'h0001_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R1 unconfigured");

    wr_cfg(2'd0, 0, mk_base(17'h2,   3'b000, 2'b11, 1, 0, 1)); wr_cfg(2'd1, 0, mk_opt(17'h1FFFF, 3'b000));
    wr_cfg(2'd0, 1, mk_base(17'h0,   3'b000, 2'b10, 0, 0, 1)); wr_cfg(2'd1, 1, mk_opt(17'h1FFF0, 3'b000));
    wr_cfg(2'd0, 2, mk_base(17'h200, 3'b100, 2'b01, 0, 0, 1)); wr_cfg(2'd1, 2, mk_opt(17'h1FFFF, 3'b111));
    wr_cfg(2'd0, 3, mk_base(17'h200, 3'b001, 2'b11, 1, 0, 1)); wr_cfg(2'd1, 3, mk_opt(17'h1FFFF, 3'b111));
    wr_cfg(2'd0, 4, mk_base(17'h400, 3'b000, 2'b11, 0, 1, 1)); wr_cfg(2'd1, 4, mk_opt(17'h1FFFF, 3'b000));
    wr_cfg(2'd0, 7, mk_base(17'h600, 3'b000, 2'b11, 0, 0, 0)); wr_cfg(2'd1, 7, mk_opt(17'h1FFFF, 3'b000));

    // R3: 0x10000 hits banks 0 and 1; bank 0 wins. R10 word on 32-bit
    req(1, 32'h0001_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h01, 2'b11, 1, 0, 0, "R3 lowest wins");
    // R2 mask region of bank 1
    req(1, 32'h0007_8001, 3'd0, 0, 0, 2'd0, 0, 0, 8'h02, 2'b10, 0, 0, 0, "R2 masked match");
    req(1, 32'h0008_0000, 3'd0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R12 miss outside mask");
    // R9 16-bit port
    req(1, 32'h0002_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R9 word refused");
    req(1, 32'h0002_0002, 3'd0, 0, 0, 2'd1, 0, 0, 8'h02, 2'b10, 0, 0, 0, "R9 even half");
    req(1, 32'h0002_0001, 3'd0, 0, 0, 2'd1, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R9 odd half");
    req(1, 32'h0002_0001, 3'd0, 0, 0, 2'd0, 0, 0, 8'h02, 2'b10, 0, 0, 0, "R9 odd byte");
    // R10 32-bit port
    req(1, 32'h0001_0002, 3'd0, 0, 0, 2'd1, 0, 0, 8'h01, 2'b11, 1, 0, 0, "R10 half at 2");
    req(1, 32'h0001_0002, 3'd0, 0, 0, 2'd2, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R10 word misaligned");
    req(1, 32'h0001_0003, 3'd0, 0, 0, 2'd0, 0, 0, 8'h01, 2'b11, 1, 0, 0, "R10 odd byte");
    req(1, 32'h0001_0000, 3'd0, 0, 0, 2'd3, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R11 size code 3");
    // R8 8-bit port, R2 type compare, R4 external override
    req(1, 32'h0100_0001, 3'b100, 0, 0, 2'd0, 0, 0, 8'h04, 2'b01, 0, 0, 0, "R8 byte");
    req(1, 32'h0100_0000, 3'b100, 0, 0, 2'd1, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R8 half refused");
    req(1, 32'h0100_0000, 3'b000, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R2 type mismatch");
    req(1, 32'h0100_0000, 3'b001, 0, 0, 2'd2, 0, 0, 8'h08, 2'b11, 1, 0, 0, "R2 type selects bank3");
    req(1, 32'h0100_0000, 3'b001, 1, 0, 2'd0, 0, 0, 8'h04, 2'b01, 0, 0, 0, "R4 external forced");
    // R6 write protect
    req(1, 32'h0200_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h10, 2'b11, 0, 0, 0, "R6 protected read");
    req(1, 32'h0001_0000, 3'd0, 0, 1, 2'd2, 0, 0, 8'h01, 2'b11, 1, 0, 0, "R6 unprotected write");
    req(1, 32'h0200_0000, 3'd0, 0, 1, 2'd2, 0, 0, 8'h00, 2'b00, 0, 0, 1, "R6 protected write");
    req(0, 32'h0, 3'd0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R7 sticky holds");
    req(0, 32'h0, 3'd0, 0, 0, 2'd0, 1, 0, 8'h00, 2'b00, 0, 0, 0, "R7 write 0 no effect");
    req(0, 32'h0, 3'd0, 0, 0, 2'd0, 1, 1, 8'h00, 2'b00, 0, 0, 0, "R7 clear");
    req(1, 32'h0200_0001, 3'd0, 0, 1, 2'd2, 0, 0, 8'h00, 2'b00, 0, 1, 0, "R11 align over protect");
    req(1, 32'h0200_0000, 3'd0, 0, 1, 2'd0, 1, 1, 8'h00, 2'b00, 0, 0, 1, "R7 set wins over clear");
    req(1, 32'h0008_0000, 3'd0, 0, 1, 2'd0, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R12 miss keeps status");
    req(0, 32'h0, 3'd0, 0, 0, 2'd0, 1, 1, 8'h00, 2'b00, 0, 0, 0, "R7 clear after set");
    // R1 bank 7 invalid then enabled
    req(1, 32'h0300_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R1 invalid bank");
    wr_cfg(2'd0, 7, mk_base(17'h600, 3'b000, 2'b11, 0, 0, 1));
    req(1, 32'h0300_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h80, 2'b11, 0, 0, 0, "R1 enabled bank");
    req(0, 32'h0300_0000, 3'd0, 0, 0, 2'd2, 0, 0, 8'h00, 2'b00, 0, 0, 0, "R5 idle after request");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule